// File: doc/BRIEF.md
# Secure/Non-Secure On-Chip Memory Partitioner

This block guards a single on-chip RAM or ROM of up to 2 MB. It divides the memory into two parts at one boundary. Everything below the boundary is secure. Everything at or above it is non-secure. The boundary moves in whole 4 KB pages. A size input sets it, and that input may be tied to a constant or driven at run time by a protection controller.

Each request carries a protection bit that marks it as secure or non-secure. A secure request may reach any page of the memory. A non-secure request that lands in the secure part is stopped and answered with an error. A request addressed beyond the 2 MB space is always stopped with an error. A permitted request is handed to the memory port for one cycle, and its response follows in the next cycle. A stopped request never touches the memory port.

The size input is copied into an internal boundary register only while the block is idle and no request is arriving. A value change therefore never affects an access that has been accepted or is being accepted.

Top module: `mem_partition_guard`

## Requirements
- R1: While reset is low and after it is released, `req_ready` is 1 and both `mem_req` and `rsp_valid` are 0 until a request is accepted.
- R2: A secure request (`req_nonsec`=0) to a byte address below 2 MB is accepted when `req_valid` and `req_ready` are both 1. In the next cycle it drives `mem_req`=1 for exactly one cycle, with `mem_addr` equal to `req_addr[20:0]` and with `mem_write` and `mem_wdata` copied from the request. The cycle after that carries `rsp_valid`=1 and `rsp_err`=0.
- R3: A non-secure request (`req_nonsec`=1) whose page number `req_addr[21:12]` is less than the boundary register is never forwarded. One cycle after acceptance the block gives `rsp_valid`=1 with `rsp_err`=1 and `rsp_rdata`=0, and `mem_req` stays 0.
- R4: A non-secure request whose page number is at least the boundary register, and that lies below 2 MB, is forwarded and answered exactly as in R2.
- R5: A boundary value of 0 makes every page reachable by non-secure requests. A boundary value of 512 or more (the input is 10 bits) blocks non-secure requests on every page.
- R6: A request with `req_addr` of 0x200000 or above gets an error response one cycle after acceptance, whatever its protection bit, and never asserts `mem_req`.
- R7: In the response cycle of a forwarded read, `rsp_rdata` equals `mem_rdata`. It is 0 in the response of a write and of any blocked request.
- R8: `req_ready` is 0 from the cycle after acceptance until the response cycle, inclusive. A `req_valid` held during that time is not taken until `req_ready` returns to 1.
- R9: The boundary register loads `sec_pages` on each clock edge at which the block is idle and `req_valid` is 0. A value change during a transaction, or in its acceptance cycle, does not affect that transaction.
- R10: Each accepted request produces exactly one response cycle. `rsp_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_pages | input | 10 | Secure region size in 4 KB pages |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nonsec | input | 1 | Protection bit, 1 = non-secure |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Request was blocked |
| rsp_rdata | output | 32 | Read data, 0 when blocked or on a write |
| mem_req | output | 1 | Memory access strobe |
| mem_write | output | 1 | Memory write enable |
| mem_addr | output | 21 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after `mem_req` |

## Verification
Secure and non-secure reads and writes are placed on both sides of a mid-range boundary. This includes the last byte of the final secure page and the first byte of the next page, which separates an off-by-one page compare from a correct one. The boundary is then set to 0, to 512 and to a value above 512. These runs tell the fully open and fully closed limits apart from the ordinary split. Addresses just past 2 MB, with either protection bit, separate the range check from the protection check. A size change made in the acceptance cycle and during a transaction, together with a request held valid back to back, shows whether the boundary is sampled only between transactions.

// File: rtl/mpg_pkg.sv
// Shared types for the memory partitioner.
// Assumes: nothing beyond IEEE 1800-2017.
package mpg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_RESP  = 2'd2
    } mpg_phase_e;

    typedef enum logic [1:0] {
        V_PASS     = 2'd0,
        V_SEC_DENY = 2'd1,
        V_RANGE    = 2'd2
    } mpg_verdict_e;

endpackage

// File: rtl/mpg_bound_reg.sv
// Holds the secure-region size used by the access check.
// The register loads the size input only when told to by the sequencer,
// which only happens between transactions.
// Assumes: synchronous active-low reset.
module mpg_bound_reg #(
    parameter int SIZE_W      = 10,
    parameter int RESET_PAGES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] size_in,
    output logic [SIZE_W-1:0] size_q
);

    // Boundary register: reset to a safe value, reload when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SIZE_W'(RESET_PAGES);
        end else if (load) begin
            size_q <= size_in;
        end
    end

endmodule

// File: rtl/mpg_access_check.sv
// Combinational verdict for one request.
// The page number is the address divided by the page size. A page below
// size_q is secure-only. A page beyond the space is out of range.
// Assumes: the size value counts pages from the bottom of the space.
module mpg_access_check
    import mpg_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int PAGE_BITS   = 12,
    parameter int SPACE_PAGES = 512,
    parameter int SIZE_W      = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              nonsec,
    input  logic [SIZE_W-1:0] size_q,
    output mpg_verdict_e      verdict
);

    localparam int PAGE_IDX_W  = ADDR_W - PAGE_BITS;
    localparam int SPACE_IDX_W = $clog2(SPACE_PAGES);
    localparam int CMP_W       = (PAGE_IDX_W > SIZE_W) ? PAGE_IDX_W : SIZE_W;

    logic [CMP_W-1:0] page_x;
    logic [CMP_W-1:0] size_x;
    logic             in_secure;
    logic             out_of_range;

    // Widen both operands to one compare width.
    always_comb begin
        page_x    = CMP_W'(addr[ADDR_W-1:PAGE_BITS]);
        size_x    = CMP_W'(size_q);
        in_secure = (page_x < size_x);
    end

    // Range check exists only when the address can exceed the space.
    generate
        if (PAGE_IDX_W > SPACE_IDX_W) begin : g_range
            always_comb out_of_range = (page_x >= CMP_W'(SPACE_PAGES));
        end else begin : g_norange
            always_comb out_of_range = 1'b0;
        end
    endgenerate

    // Range failure takes priority over protection failure.
    always_comb begin
        if (out_of_range) begin
            verdict = V_RANGE;
        end else if (nonsec && in_secure) begin
            verdict = V_SEC_DENY;
        end else begin
            verdict = V_PASS;
        end
    end

endmodule

// File: rtl/mpg_sequencer.sv
// Transaction sequencer: accepts one request at a time. It forwards
// permitted requests to the memory for one cycle and then gives a single
// response cycle. Blocked requests go straight to an error response.
// Assumes: memory read data is valid the cycle after the strobe and the
// response is never stalled.
module mpg_sequencer
    import mpg_pkg::*;
#(
    parameter int MEM_AW = 21,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [MEM_AW-1:0] req_addr_lo,
    input  logic [DATA_W-1:0] req_wdata,
    input  mpg_verdict_e      verdict,
    output logic              req_ready,
    output logic              cfg_load,
    output logic              mem_req,
    output logic              mem_write,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    mpg_phase_e        ph_q;
    logic              wr_q;
    logic              err_q;
    logic [MEM_AW-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;

    // Handshake and boundary-load decode.
    always_comb begin
        req_ready = (ph_q == PH_IDLE);
        accept    = req_ready && req_valid;
        cfg_load  = req_ready && !req_valid;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            unique case (ph_q)
                PH_IDLE:  if (accept) ph_q <= (verdict == V_PASS) ? PH_ISSUE : PH_RESP;
                PH_ISSUE: ph_q <= PH_RESP;
                PH_RESP:  ph_q <= PH_IDLE;
                default:  ph_q <= PH_IDLE;
            endcase
        end
    end

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            err_q   <= (verdict != V_PASS);
            addr_q  <= req_addr_lo;
            wdata_q <= req_wdata;
        end
    end

    // Memory-side drive from the captured request.
    always_comb begin
        mem_req   = (ph_q == PH_ISSUE);
        mem_write = mem_req && wr_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
    end

    // Response drive: data only for a forwarded read.
    always_comb begin
        rsp_valid = (ph_q == PH_RESP);
        rsp_err   = rsp_valid && err_q;
        rsp_rdata = (rsp_valid && !err_q && !wr_q) ? mem_rdata : '0;
    end

endmodule

// File: rtl/mem_partition_guard.sv
// Top of the secure/non-secure memory partitioner.
// It connects the boundary register, the access check and the sequencer.
// Assumes: a single boundary, secure part at low addresses, page-aligned.
module mem_partition_guard
    import mpg_pkg::*;
#(
    parameter int  ADDR_W      = 22,
    parameter int  DATA_W      = 32,
    parameter int  PAGE_BITS   = 12,
    parameter int  SPACE_PAGES = 512,
    parameter int  RESET_PAGES = SPACE_PAGES,
    localparam int SIZE_W      = $clog2(SPACE_PAGES) + 1,
    localparam int MEM_AW      = $clog2(SPACE_PAGES) + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] sec_pages,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_nonsec,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic [SIZE_W-1:0] size_q;
    logic              cfg_load;
    mpg_verdict_e      verdict;

    mpg_bound_reg #(
        .SIZE_W      (SIZE_W),
        .RESET_PAGES (RESET_PAGES)
    ) u_bound (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .size_in (sec_pages),
        .size_q  (size_q)
    );

    mpg_access_check #(
        .ADDR_W      (ADDR_W),
        .PAGE_BITS   (PAGE_BITS),
        .SPACE_PAGES (SPACE_PAGES),
        .SIZE_W      (SIZE_W)
    ) u_check (
        .addr    (req_addr),
        .nonsec  (req_nonsec),
        .size_q  (size_q),
        .verdict (verdict)
    );

    mpg_sequencer #(
        .MEM_AW (MEM_AW),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr_lo (req_addr[MEM_AW-1:0]),
        .req_wdata   (req_wdata),
        .verdict     (verdict),
        .req_ready   (req_ready),
        .cfg_load    (cfg_load),
        .mem_req     (mem_req),
        .mem_write   (mem_write),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata)
    );

endmodule

// File: rtl/mpg_checker.sv
// Protocol and protection properties for mem_partition_guard, observed
// at its ports. Attached by the bind at the end of this file.
module mpg_checker #(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 32,
    parameter int PAGE_BITS   = 12,
    parameter int SPACE_PAGES = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              mem_req,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata
);

    logic beyond_space;

    // Page index of the request compared with the size of the space.
    always_comb beyond_space = (32'(req_addr >> PAGE_BITS) >= 32'(SPACE_PAGES));

    // R2: the memory strobe lasts one cycle and is followed by a clean response.
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (!mem_req && rsp_valid && !rsp_err));

    // R3: an error response carries zero data.
    assert_err_zero_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R6: an address beyond the space is answered with an error and never forwarded.
    assert_beyond_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && beyond_space) |=> (!mem_req && rsp_valid && rsp_err));

    // R8: no request is taken while a transaction is in progress.
    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rsp_valid) |-> !req_ready);

    // R10: a response lasts a single cycle.
    assert_single_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind mem_partition_guard mpg_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PAGE_BITS   (PAGE_BITS),
    .SPACE_PAGES (SPACE_PAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .mem_req   (mem_req),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
);

// File: tb/mem_partition_guard_tb.sv
// Bench for mem_partition_guard. A behavioural model predicts every
// output on every clock and the outputs are compared at the falling edge.
module mem_partition_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  sec_pages = 10'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_nonsec = 1'b0;
    logic [21:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        mem_req;
    logic        mem_write;
    logic [20:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit r9_flag = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mem_partition_guard u_dut (
        .clk(clk), .rst_n(rst_n), .sec_pages(sec_pages),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_nonsec(req_nonsec), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] pat(input logic [20:0] a);
        return {11'h5A3, a} ^ 32'h1357_9BDF;
    endfunction

    // Memory stand-in: read data appears the cycle after the strobe.
    always @(posedge clk) begin
        if (mem_req && !mem_write) mem_rdata <= pat(mem_addr);
    end

    // Reference model state.
    int          m_cfg = 512;
    int          m_ph = 0;
    logic        m_wr, m_err;
    logic [20:0] m_addr;
    logic [31:0] m_wd;
    string       m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 512;
            m_ph  = 0;
        end else begin
            case (m_ph)
                0: begin
                    if (req_valid) begin
                        int  page;
                        bit  oor;
                        bit  blk;
                        page   = int'(req_addr >> 12);
                        oor    = (page >= 512);
                        blk    = oor || (req_nonsec && (page < m_cfg));
                        m_wr   = req_write;
                        m_err  = blk;
                        m_addr = req_addr[20:0];
                        m_wd   = req_wdata;
                        if (r9_flag)                         m_tag = "R9";
                        else if (oor)                        m_tag = "R6";
                        else if (m_cfg == 0 || m_cfg >= 512) m_tag = "R5";
                        else if (blk)                        m_tag = "R3";
                        else if (!req_nonsec)                m_tag = "R2";
                        else                                 m_tag = "R4";
                        m_ph = blk ? 2 : 1;
                    end else begin
                        m_cfg = int'(sec_pages);
                    end
                end
                1: m_ph = 2;
                default: m_ph = 0;
            endcase
        end
    end

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            cmp("R8", "req_ready", 32'(req_ready), 32'(m_ph == 0));
            cmp(m_tag, "mem_req", 32'(mem_req), 32'(m_ph == 1));
            if (m_ph == 1) begin
                cmp(m_tag, "mem_addr", 32'(mem_addr), 32'(m_addr));
                cmp(m_tag, "mem_write", 32'(mem_write), 32'(m_wr));
                if (m_wr) cmp(m_tag, "mem_wdata", mem_wdata, m_wd);
            end
            cmp("R10", "rsp_valid", 32'(rsp_valid), 32'(m_ph == 2));
            if (m_ph == 2) begin
                cmp(m_tag, "rsp_err", 32'(rsp_err), 32'(m_err));
                cmp("R7", "rsp_rdata", rsp_rdata, (!m_err && !m_wr) ? pat(m_addr) : 32'h0);
            end
        end
    end

    task automatic send(input logic [21:0] a, input logic w, input logic ns, input logic [31:0] d);
        @(negedge clk);
        req_valid  = 1'b1;
        req_addr   = a;
        req_write  = w;
        req_nonsec = ns;
        req_wdata  = d;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected<20000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        cmp("R1", "req_ready in reset", 32'(req_ready), 32'h1);
        cmp("R1", "mem_req in reset", 32'(mem_req), 32'h0);
        cmp("R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        sec_pages = 10'd4;
        repeat (3) @(negedge clk);

        // R2/R4/R3 around a boundary of 4 pages.
        send(22'h00_0000, 1'b0, 1'b0, 32'h0);          // R2 secure read, secure page
        send(22'h1F_F000, 1'b1, 1'b0, 32'hCAFE_0001);  // R2 secure write, top page
        send(22'h00_3FFC, 1'b0, 1'b1, 32'h0);          // R3 last secure page
        send(22'h00_3FFF, 1'b1, 1'b1, 32'hDEAD_0002);  // R3 blocked write
        send(22'h00_4000, 1'b0, 1'b1, 32'h0);          // R4 first open page
        send(22'h00_4004, 1'b1, 1'b1, 32'hBEEF_0003);  // R4 open write
        // R6: beyond the space.
        send(22'h20_0000, 1'b0, 1'b0, 32'h0);
        send(22'h3F_FFFC, 1'b1, 1'b1, 32'h1);
        // R5: limits of the size value.
        sec_pages = 10'd0;
        send(22'h00_0000, 1'b0, 1'b1, 32'h0);
        sec_pages = 10'd512;
        send(22'h1F_FFFC, 1'b0, 1'b1, 32'h0);
        send(22'h1F_FFFC, 1'b0, 1'b0, 32'h0);
        sec_pages = 10'd700;
        send(22'h01_0000, 1'b1, 1'b1, 32'h7);
        // R9: change in the acceptance cycle and during the transaction.
        sec_pages = 10'd1;
        repeat (2) @(negedge clk);
        r9_flag = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 22'h00_0010; req_nonsec = 1'b1; req_write = 1'b0;
        sec_pages = 10'd0;                              // same cycle as acceptance
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        sec_pages = 10'd0;
        repeat (2) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 22'h00_0020; req_nonsec = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        sec_pages = 10'd100;                            // during the transaction
        repeat (4) @(negedge clk);
        r9_flag = 1'b0;
        // R8: request held valid back to back.
        sec_pages = 10'd8;
        repeat (2) @(negedge clk);
        req_valid = 1'b1; req_addr = 22'h00_9000; req_nonsec = 1'b1; req_write = 1'b0;
        repeat (9) @(negedge clk);
        req_addr = 22'h00_1000;
        repeat (6) @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        // Mixed sweep.
        for (int i = 0; i < 40; i++) begin
            sec_pages = 10'((i * 37) % 530);
            send(22'((i * 22'h0_D3F5) % 22'h24_0000), 1'(i % 3 == 0), 1'(i % 2), 32'(i * 32'h1111_0101));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule